// File: doc/BRIEF.md
# Fixed-Point Scale Phase Accumulator

This block produces the sampling plan for one dimension of a polyphase video resampler. Software or a sequencer gives it a shrink factor (input size over output size, times 2^20), the number of output samples in the line or column, the number of filter phases to use and an initial sub-sample offset. After a start pulse the block presents, for the current output sample, the integer index of the input sample the filter window is anchored on, a phase index that selects a coefficient row, and an advance count: the number of input samples the input stream must move on before the next output sample.

A downstream filter consumes these values and pulses the step strobe once per output sample it has produced. The block then moves to the next output sample. A shrink factor below one up-scales, so the advance count is 0 or 1 and a 0 repeats the same input sample. A shrink factor above one down-scales, so the advance count can exceed one. After the programmed number of steps the block reports done and ignores further steps until the next start.

Top module: `scl_phase_accum`

## Requirements
- R1: After reset, pos_o, phase_o and adv_o are 0 and busy_o and done_o are low.
- R2: One cycle after start_i, pos_o is 0, the fractional position is start_frac_i, and adv_o is floor((start_frac_i + shrink_i) / 2^20). shrink_i holds the integer part in bits 23:20 and the fraction in bits 19:0.
- R3: Each accepted step adds the previous adv_o to pos_o, sets the fractional position to (fraction + shrink) mod 2^20, and presents the new adv_o for the new position, one cycle after the step.
- R4: With a shrink factor below 2^20 (up-scaling), adv_o is always 0 or 1, and a 0 keeps the same input index for the next output sample.
- R5: With a shrink factor above 2^20 (down-scaling), adv_o can exceed 1 and reaches 16 for a shrink factor of 0xFFFFFF and a fraction of 0xFFFFF.
- R6: phase_o is floor(fraction × P / 2^20), where P is num_phases_i latched at start, clamped to MAX_PHASES; P = 0 gives phase 0.
- R7: done_o rises and busy_o falls in the cycle after the out_size_i-th accepted step; an out_size_i of 0 sets done_o directly after start.
- R8: step_i while busy_o is low changes none of pos_o, phase_o, adv_o.
- R9: start_i while busy_o is high abandons the current run and begins a new one with the configuration present at that start.
- R10: shrink_i, out_size_i, num_phases_i and start_frac_i are sampled only with start_i; changing them during a run has no effect on that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a run; samples the configuration |
| step_i | input | 1 | One output sample has been consumed |
| shrink_i | input | 24 | Shrink factor, 4.20 fixed point |
| start_frac_i | input | 20 | Initial fractional position |
| out_size_i | input | 13 | Output samples in the run |
| num_phases_i | input | 7 | Run-time filter phase count |
| pos_o | output | 18 | Integer input index of the current output sample |
| phase_o | output | 6 | Coefficient phase row |
| adv_o | output | 5 | Input samples to advance before the next output sample |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | The run has produced all its output samples |

## Verification
A wrong accumulated fraction shows on phase_o and adv_o in the very cycle after the step that produced it, and from the next step on it also drifts pos_o, so every sample of every run is compared with an independently computed position, phase and advance. A wrong sample counter shows as done_o rising a step early or late, checked at the exact step count, including a zero-length run. Stale configuration or a missed restart shows on the first sample after start, which is checked before any step is taken.

// File: rtl/scl_pkg.sv
package scl_pkg;

    // Run-state of the sequencing control.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } scl_state_e;

endpackage

// File: rtl/scl_frac_add.sv
// Adds a fixed-point increment to a pure fraction; splits integer carry and wrapped fraction.
module scl_frac_add #(
    parameter int INT_W  = 4,
    parameter int FRAC_W = 20
) (
    input  logic [FRAC_W-1:0]       frac_i,
    input  logic [INT_W+FRAC_W-1:0] inc_i,
    output logic [INT_W:0]          carry_o,
    output logic [FRAC_W-1:0]       frac_o
);
    localparam int SUM_W = INT_W + FRAC_W + 1;

    logic [SUM_W-1:0] sum;

    always_comb begin
        sum     = SUM_W'(frac_i) + SUM_W'(inc_i);
        carry_o = sum[FRAC_W +: INT_W+1];
        frac_o  = sum[FRAC_W-1:0];
    end

endmodule

// File: rtl/scl_phase_map.sv
// Maps a fractional position onto one of the run-time number of phases.
module scl_phase_map #(
    parameter int FRAC_W     = 20,
    parameter int MAX_PHASES = 64,
    localparam int PH_W      = $clog2(MAX_PHASES),
    localparam int NP_W      = PH_W + 1
) (
    input  logic [FRAC_W-1:0] frac_i,
    input  logic [NP_W-1:0]   num_phases_i,
    output logic [PH_W-1:0]   phase_o
);
    localparam int PROD_W = FRAC_W + NP_W;

    logic [NP_W-1:0]   np_eff;
    logic [PROD_W-1:0] prod;

    always_comb begin
        if (num_phases_i > NP_W'(MAX_PHASES)) begin
            np_eff = NP_W'(MAX_PHASES);
        end else begin
            np_eff = num_phases_i;
        end
        prod    = PROD_W'(frac_i) * PROD_W'(np_eff);
        phase_o = PH_W'(prod >> FRAC_W);
    end

endmodule

// File: rtl/scl_seq_ctrl.sv
// Counts accepted steps against the latched output size.
module scl_seq_ctrl
    import scl_pkg::*;
#(
    parameter int SIZE_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              step_i,
    input  logic [SIZE_W-1:0] size_i,
    output logic              take_o,
    output logic              busy_o,
    output logic              done_o
);
    typedef struct packed {
        scl_state_e        st;
        logic [SIZE_W-1:0] cnt;
        logic [SIZE_W-1:0] size;
    } ctrl_t;

    ctrl_t c_d, c_q;
    logic  last_step;

    always_comb begin
        c_d       = c_q;
        take_o    = step_i && !start_i && (c_q.st == ST_RUN);
        last_step = ({1'b0, c_q.cnt} + (SIZE_W+1)'(1)) == {1'b0, c_q.size};
        if (start_i) begin
            c_d.size = size_i;
            c_d.cnt  = '0;
            c_d.st   = (size_i == '0) ? ST_DONE : ST_RUN;
        end else if (take_o) begin
            c_d.cnt = c_q.cnt + SIZE_W'(1);
            if (last_step) begin
                c_d.st = ST_DONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '{st: ST_IDLE, cnt: '0, size: '0};
        end else begin
            c_q <= c_d;
        end
    end

    assign busy_o = (c_q.st == ST_RUN);
    assign done_o = (c_q.st == ST_DONE);

    // R7: while running, fewer steps than the size have been taken
    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == ST_RUN) |-> (c_q.cnt < c_q.size));

    // R7: done means exactly size steps were taken
    p_done_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == ST_DONE) |-> (c_q.cnt == c_q.size));

    // R7: a zero-size run finishes at once
    p_zero_size_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && size_i == '0) |=> done_o);

endmodule

// File: rtl/scl_phase_accum.sv
// Per-dimension source position / phase generator for a polyphase resampler.
module scl_phase_accum
    import scl_pkg::*;
#(
    parameter int SF_INT_W   = 4,
    parameter int SF_FRAC_W  = 20,
    parameter int SIZE_W     = 13,
    parameter int MAX_PHASES = 64,
    localparam int SF_W      = SF_INT_W + SF_FRAC_W,
    localparam int PH_W      = $clog2(MAX_PHASES),
    localparam int NP_W      = PH_W + 1,
    localparam int ADV_W     = SF_INT_W + 1,
    localparam int POS_W     = SIZE_W + ADV_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic                 step_i,
    input  logic [SF_W-1:0]      shrink_i,
    input  logic [SF_FRAC_W-1:0] start_frac_i,
    input  logic [SIZE_W-1:0]    out_size_i,
    input  logic [NP_W-1:0]      num_phases_i,
    output logic [POS_W-1:0]     pos_o,
    output logic [PH_W-1:0]      phase_o,
    output logic [ADV_W-1:0]     adv_o,
    output logic                 busy_o,
    output logic                 done_o
);
    typedef struct packed {
        logic [SF_W-1:0]      sf;
        logic [NP_W-1:0]      np;
        logic [SF_FRAC_W-1:0] frac;
        logic [SF_FRAC_W-1:0] wrap;
        logic [POS_W-1:0]     pos;
        logic [PH_W-1:0]      phase;
        logic [ADV_W-1:0]     adv;
    } acc_t;

    acc_t s_d, s_q;

    logic                 take;
    logic [ADV_W-1:0]     la_carry;
    logic [SF_FRAC_W-1:0] la_frac;
    logic [PH_W-1:0]      ph_next;

    scl_seq_ctrl #(
        .SIZE_W (SIZE_W)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .step_i  (step_i),
        .size_i  (out_size_i),
        .take_o  (take),
        .busy_o  (busy_o),
        .done_o  (done_o)
    );

    // Look-ahead adder: carry and wrapped fraction for the sample after s_d.
    scl_frac_add #(
        .INT_W  (SF_INT_W),
        .FRAC_W (SF_FRAC_W)
    ) u_look (
        .frac_i  (s_d.frac),
        .inc_i   (s_d.sf),
        .carry_o (la_carry),
        .frac_o  (la_frac)
    );

    scl_phase_map #(
        .FRAC_W     (SF_FRAC_W),
        .MAX_PHASES (MAX_PHASES)
    ) u_phase (
        .frac_i       (s_d.frac),
        .num_phases_i (s_d.np),
        .phase_o      (ph_next)
    );

    always_comb begin
        s_d = s_q;
        if (start_i) begin
            s_d.sf   = shrink_i;
            s_d.np   = num_phases_i;
            s_d.frac = start_frac_i;
            s_d.pos  = '0;
        end else if (take) begin
            s_d.frac = s_q.wrap;
            s_d.pos  = s_q.pos + POS_W'(s_q.adv);
        end
        s_d.wrap  = la_frac;
        s_d.adv   = la_carry;
        s_d.phase = ph_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pos_o   = s_q.pos;
    assign phase_o = s_q.phase;
    assign adv_o   = s_q.adv;

    // R2: a start always restarts the input index at zero
    p_start_pos_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (pos_o == '0));

    // R3: an accepted step moves the index by the advance shown before it
    p_pos_adv_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && step_i && !start_i) |=> (pos_o == $past(pos_o) + POS_W'($past(adv_o))));

    // R4: up-scaling never skips an input sample
    p_upscale_adv_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && s_q.sf[SF_W-1:SF_FRAC_W] == '0) |-> (adv_o <= ADV_W'(1)));

    // R6: the phase stays below the effective phase count
    p_phase_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.np != '0 && s_q.np <= NP_W'(MAX_PHASES)) |-> (NP_W'(phase_o) < s_q.np));

    // R8: without a run or a start, the outputs hold
    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> ($stable(pos_o) && $stable(phase_o) && $stable(adv_o)));

endmodule

// File: tb/scl_phase_accum_bench.sv
module scl_phase_accum_bench;
    localparam int SF_W  = 24;
    localparam int FR_W  = 20;
    localparam int SZ_W  = 13;
    localparam int NP_W  = 7;
    localparam int PH_W  = 6;
    localparam int ADV_W = 5;
    localparam int POS_W = 18;
    localparam longint ONE  = 64'd1 << FR_W;
    localparam longint FMSK = ONE - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic step_i = 1'b0;
    logic [SF_W-1:0]  shrink_i = '0;
    logic [FR_W-1:0]  start_frac_i = '0;
    logic [SZ_W-1:0]  out_size_i = '0;
    logic [NP_W-1:0]  num_phases_i = '0;
    logic [POS_W-1:0] pos_o;
    logic [PH_W-1:0]  phase_o;
    logic [ADV_W-1:0] adv_o;
    logic busy_o, done_o;

    always #10 clk = ~clk;

    scl_phase_accum u_scl_phase_accum (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .step_i(step_i),
        .shrink_i(shrink_i), .start_frac_i(start_frac_i), .out_size_i(out_size_i),
        .num_phases_i(num_phases_i), .pos_o(pos_o), .phase_o(phase_o),
        .adv_o(adv_o), .busy_o(busy_o), .done_o(done_o)
    );

    int checks = 0;
    int errors = 0;
    longint m_frac, m_pos, m_sf, m_np;
    longint max_adv;
    int zero_adv;

    task automatic chk(string tag, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic longint exp_phase();
        longint npc = (m_np > 64) ? 64 : m_np;
        return (m_frac * npc) >> FR_W;
    endfunction

    function automatic longint exp_adv();
        return (m_frac + m_sf) >> FR_W;
    endfunction

    task automatic check_model(string tag);
        chk(tag, "pos", pos_o, m_pos);
        chk(tag, "phase", phase_o, exp_phase());
        chk(tag, "adv", adv_o, exp_adv());
        if (longint'(adv_o) > max_adv) max_adv = adv_o;
        if (adv_o == 0) zero_adv++;
    endtask

    task automatic do_start(longint sf, longint size, longint np, longint sp);
        shrink_i = SF_W'(sf);
        out_size_i = SZ_W'(size);
        num_phases_i = NP_W'(np);
        start_frac_i = FR_W'(sp);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        m_sf = sf; m_np = np; m_frac = sp; m_pos = 0;
        max_adv = 0; zero_adv = 0;
    endtask

    task automatic do_step();
        longint a = exp_adv();
        step_i = 1'b1;
        @(negedge clk);
        step_i = 1'b0;
        m_pos += a;
        m_frac = (m_frac + m_sf) & FMSK;
    endtask

    task automatic run_case(string tag, longint sf, longint size, longint np, longint sp);
        do_start(sf, size, np, sp);
        for (int k = 0; k < size; k++) begin
            check_model(tag);
            chk(tag, "busy", busy_o, 1);
            do_step();
        end
        chk(tag, "done at end", done_o, 1);
        chk(tag, "busy at end", busy_o, 0);
    endtask

    task automatic t_reset();
        chk("R1", "pos", pos_o, 0);
        chk("R1", "phase", phase_o, 0);
        chk("R1", "adv", adv_o, 0);
        chk("R1", "busy", busy_o, 0);
        chk("R1", "done", done_o, 0);
    endtask

    task automatic t_unity();
        run_case("R3", ONE, 6, 8, 0);
        chk("R3", "unity final pos", pos_o, 6);
    endtask

    task automatic t_start_phase();
        do_start(64'h180000, 8, 8, 64'h40000);
        chk("R2", "start pos", pos_o, 0);
        chk("R2", "start phase", phase_o, 2);
        chk("R2", "start adv", adv_o, 1);
        for (int k = 0; k < 8; k++) begin
            check_model("R3");
            do_step();
        end
        chk("R7", "done", done_o, 1);
    endtask

    task automatic t_upscale();
        run_case("R4", 699051, 12, 16, 0);
        chk("R4", "max adv up-scale", max_adv, 1);
        chk("R4", "repeat seen", (zero_adv > 0) ? 1 : 0, 1);
    endtask

    task automatic t_downscale();
        do_start(64'hFFFFFF, 5, 64, 0);
        chk("R5", "first adv", adv_o, 15);
        do_step();
        chk("R5", "second adv", adv_o, 16);
        chk("R5", "second pos", pos_o, 15);
        for (int k = 1; k < 5; k++) begin
            check_model("R5");
            do_step();
        end
        chk("R7", "done", done_o, 1);
    endtask

    task automatic t_phases();
        run_case("R6", 64'h0C0000, 6, 100, 64'h12345);
        run_case("R6", 64'h0C0000, 4, 0, 64'h80000);
        run_case("R6", 64'h1A0000, 7, 5, 64'h33333);
    endtask

    task automatic t_done();
        do_start(ONE, 3, 4, 0);
        do_step();
        do_step();
        chk("R7", "busy before last", busy_o, 1);
        chk("R7", "done before last", done_o, 0);
        do_step();
        chk("R7", "done after last", done_o, 1);
        chk("R7", "busy after last", busy_o, 0);
        do_start(ONE, 0, 4, 0);
        chk("R7", "zero size done", done_o, 1);
        chk("R7", "zero size busy", busy_o, 0);
    endtask

    task automatic t_ignore();
        longint p, ph, a;
        run_case("R8", 64'h0A0000, 3, 8, 0);
        p = pos_o; ph = phase_o; a = adv_o;
        for (int k = 0; k < 3; k++) begin
            step_i = 1'b1;
            @(negedge clk);
        end
        step_i = 1'b0;
        chk("R8", "pos after ignored steps", pos_o, p);
        chk("R8", "phase after ignored steps", phase_o, ph);
        chk("R8", "adv after ignored steps", adv_o, a);
        chk("R8", "still done", done_o, 1);
    endtask

    task automatic t_restart();
        do_start(64'h300000, 10, 16, 0);
        do_step();
        do_step();
        do_step();
        do_start(64'h080000, 4, 32, 64'h20000);
        chk("R9", "restart busy", busy_o, 1);
        for (int k = 0; k < 4; k++) begin
            check_model("R9");
            do_step();
        end
        chk("R9", "restart done at new size", done_o, 1);
    endtask

    task automatic t_latch();
        do_start(64'h140000, 6, 8, 64'h10000);
        check_model("R10");
        do_step();
        shrink_i = 24'hF00000;
        num_phases_i = 7'd3;
        out_size_i = 13'd2;
        start_frac_i = 20'hFFFFF;
        for (int k = 1; k < 6; k++) begin
            check_model("R10");
            chk("R10", "busy", busy_o, 1);
            do_step();
        end
        chk("R10", "done at latched size", done_o, 1);
    endtask

    initial begin
        #(20 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_unity();
        t_start_phase();
        t_upscale();
        t_downscale();
        t_phases();
        t_done();
        t_ignore();
        t_restart();
        t_latch();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule